// File: doc/BRIEF.md
# Lockable General-Purpose I/O Port

This block is an N-pin general-purpose I/O port that software reaches over a simple synchronous register bus with address, write enable, read strobe, write data and registered read data. Each pin has its own direction mode: sampled input, driven from the port's output word, or alternate. In alternate mode, a per-pin selector picks one of several internal peripheral signals and places it on the pin. Drive type, slew and bias fields are plain storage that other logic may read. They have no electrical effect in this block.

Software can write the whole output word at once, or change single bits atomically with set/clear and flip writes. It can read the synchronized pin levels at any time. A keyed three-write, one-read handshake freezes all configuration registers, and only reset releases them. The pads are driven from registers. After reset every pin is an undriven input, except the pins marked as debug pins, which come up in alternate mode.

Top module: `gpio_port`

## Requirements
- R1: After reset the output word reads 0, the freeze register reads 0, and the direction register has mode 2'b10 (alternate) on debug pins and 2'b00 elsewhere. One cycle after reset is released, `pad_oe` is high only on debug pins.
- R2: A read of the level register (address 5) returns each pin's level after a two-flop synchronizer, whatever the pin's mode. A pad change made before edge k is returned by a read strobed at edge k+2.
- R3: A write to the output register (address 6) replaces the output word, and a read of address 6 returns the stored word.
- R4: A write to address 7 sets the output bits marked in wdata[N-1:0] and clears those marked in wdata[2N-1:N]. When a bit is marked for both, it ends up set. Unmarked bits keep their value.
- R5: A write to address 8 inverts each output bit whose wdata bit is 1 and leaves the others unchanged.
- R6: Pin p's mode is field [2p+1:2p] of address 0. Mode 2'b01 drives the output bit with `pad_oe` high. Modes 2'b00 and 2'b11 leave `pad_oe` and `pad_o` low. Pad outputs follow one cycle after the controlling registers.
- R7: Mode 2'b10 drives `af_src_i[p*2^AF_SEL_W + s]` onto pin p, where s is field [AF_SEL_W*(p+1)-1:AF_SEL_W*p] of address 4. A change of the selected source reaches `pad_o` one cycle later.
- R8: Address 9 is the freeze register. After three writes carrying key 16'hC35A in wdata[31:16] with wdata[0] = 1, 0, 1, followed by a read of address 9, reads of address 9 return bit 0 = 1. From then on, writes to addresses 0–4 (direction, drive type, slew, bias, function select) are ignored, and output writes keep working.
- R9: A write to address 9 with a wrong key, a wrong bit value or the wrong order, or a read out of order, restarts the handshake, and the port stays unfrozen.
- R10: Only reset clears the frozen state. Writes to address 9 while frozen have no effect.
- R11: Addresses 1, 2 and 3 store N, 2N and 2N bits, read back exactly what was written, and read upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read strobe; data appears on `bus_rdata` after the edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data, zero when no read was strobed |
| pad_i | input | N_PINS | Pin levels from the pads (asynchronous) |
| pad_o | output | N_PINS | Registered pin output values |
| pad_oe | output | N_PINS | Registered pin output enables |
| af_src_i | input | N_PINS*2^AF_SEL_W | Internal peripheral signals, one group per pin |

## Verification
A vector table drives the output word through full writes, set-only, clear-only, set-and-clear on the same bits, flips and empty set/clear writes. These patterns separate a correct set-wins rule from a clear-wins or ignored-operand bug. Mixed pin modes check that input, output and alternate pins drive correctly side by side, and that the level register ignores the mode. The alternate selector is tried with distinct sources per pin so that a wrong index shows up. Freeze handshakes are tried with a repeated bit and a wrong key, which must stay unfrozen, and then with the correct handshake. The correct handshake must block configuration writes but not output writes, and must survive an unlock attempt until reset.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    PIN_IN  = 2'b00,
    PIN_OUT = 2'b01,
    PIN_ALT = 2'b10,
    PIN_OFF = 2'b11
  } pin_mode_e;

  localparam logic [ADDR_W-1:0] A_DIR     = 4'd0;
  localparam logic [ADDR_W-1:0] A_DRVTYPE = 4'd1;
  localparam logic [ADDR_W-1:0] A_SLEW    = 4'd2;
  localparam logic [ADDR_W-1:0] A_BIAS    = 4'd3;
  localparam logic [ADDR_W-1:0] A_FUNC    = 4'd4;
  localparam logic [ADDR_W-1:0] A_LEVEL   = 4'd5;
  localparam logic [ADDR_W-1:0] A_OUTVAL  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SETCLR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_FLIP    = 4'd8;
  localparam logic [ADDR_W-1:0] A_FREEZE  = 4'd9;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl #(
  parameter int               KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY   = 16'hC35A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             bit_i,
  output logic             locked_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_LOCKED
  } lock_st_e;

  lock_st_e state_q, state_n;
  logic     key_ok;

  assign key_ok = (key_i == KEY);

  always_comb begin
    state_n = state_q;
    if (state_q != ST_LOCKED) begin
      if (wr_i) begin
        case (state_q)
          ST_IDLE: state_n = (key_ok && bit_i)  ? ST_K1 : ST_IDLE;
          ST_K1:   state_n = (key_ok && !bit_i) ? ST_K2 : ST_IDLE;
          ST_K2:   state_n = (key_ok && bit_i)  ? ST_K3 : ST_IDLE;
          default: state_n = ST_IDLE;
        endcase
      end else if (rd_i) begin
        state_n = (state_q == ST_K3) ? ST_LOCKED : ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_n;
  end

  assign locked_o = (state_q == ST_LOCKED);

  // R10: once frozen, only reset leaves the state
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);

  // R8 / R9: freezing needs the closing read after the third key write
  assert_lock_needs_read_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(state_q == ST_K3 && rd_i && !wr_i));
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_pkg::*;
#(
  parameter int AF_SEL_W = 2,
  localparam int NUM_AF  = 1 << AF_SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_i,
  input  logic                outval_i,
  input  logic [AF_SEL_W-1:0] sel_i,
  input  logic [NUM_AF-1:0]   af_src_i,
  output logic                pad_o,
  output logic                pad_oe
);
  logic o_n, oe_n;

  always_comb begin
    o_n  = 1'b0;
    oe_n = 1'b0;
    case (pin_mode_e'(mode_i))
      PIN_OUT: begin o_n = outval_i;        oe_n = 1'b1; end
      PIN_ALT: begin o_n = af_src_i[sel_i]; oe_n = 1'b1; end
      default: begin o_n = 1'b0;            oe_n = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
    end else begin
      pad_o  <= o_n;
      pad_oe <= oe_n;
    end
  end

  // R6: input and off modes never drive the pad
  assert_input_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PIN_IN || mode_i == PIN_OFF) |=> (!pad_oe && !pad_o));

  // R7: alternate mode carries the selected source
  assert_alt_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_i == PIN_ALT) |=> (pad_oe && pad_o == $past(af_src_i[sel_i])));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int                N_PINS   = 8,
  parameter int                AF_SEL_W = 2,
  parameter int                DW       = 32,
  parameter logic [N_PINS-1:0] DBG_PINS = 'h3,
  parameter logic [DW/2-1:0]   LOCK_KEY = 'hC35A,
  localparam int               NUM_AF   = 1 << AF_SEL_W,
  localparam int               MODE_W   = 2 * N_PINS,
  localparam int               FUNC_W   = AF_SEL_W * N_PINS,
  localparam int               KEY_W    = DW / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [N_PINS-1:0]        pad_i,
  output logic [N_PINS-1:0]        pad_o,
  output logic [N_PINS-1:0]        pad_oe,
  input  logic [N_PINS*NUM_AF-1:0] af_src_i
);
  function automatic logic [MODE_W-1:0] mode_reset();
    logic [MODE_W-1:0] m;
    m = '0;
    for (int p = 0; p < N_PINS; p++)
      m[2*p +: 2] = DBG_PINS[p] ? PIN_ALT : PIN_IN;
    return m;
  endfunction

  localparam logic [MODE_W-1:0] MODE_RST = mode_reset();

  logic [MODE_W-1:0] mode_q;
  logic [N_PINS-1:0] drvtype_q;
  logic [MODE_W-1:0] slew_q;
  logic [MODE_W-1:0] bias_q;
  logic [FUNC_W-1:0] func_q;
  logic [N_PINS-1:0] outval_q, outval_n;
  logic [N_PINS-1:0] level;
  logic [DW-1:0]     rd_n;
  logic              locked;
  logic              cfg_we;
  logic [N_PINS-1:0] set_m, clr_m;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pad_i),
    .q_o (level)
  );

  gpio_lock_ctrl #(.KEY_W(KEY_W), .KEY(LOCK_KEY)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (bus_we && bus_addr == A_FREEZE),
    .rd_i     (bus_re && !bus_we && bus_addr == A_FREEZE),
    .key_i    (bus_wdata[DW-1:KEY_W]),
    .bit_i    (bus_wdata[0]),
    .locked_o (locked)
  );

  assign cfg_we = bus_we && !locked;
  assign set_m  = bus_wdata[N_PINS-1:0];
  assign clr_m  = bus_wdata[2*N_PINS-1:N_PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RST;
      drvtype_q <= '0;
      slew_q    <= '0;
      bias_q    <= '0;
      func_q    <= '0;
    end else if (cfg_we) begin
      case (bus_addr)
        A_DIR:     mode_q    <= bus_wdata[MODE_W-1:0];
        A_DRVTYPE: drvtype_q <= bus_wdata[N_PINS-1:0];
        A_SLEW:    slew_q    <= bus_wdata[MODE_W-1:0];
        A_BIAS:    bias_q    <= bus_wdata[MODE_W-1:0];
        A_FUNC:    func_q    <= bus_wdata[FUNC_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    outval_n = outval_q;
    if (bus_we) begin
      case (bus_addr)
        A_OUTVAL: outval_n = bus_wdata[N_PINS-1:0];
        A_SETCLR: outval_n = (outval_q & ~clr_m) | set_m;
        A_FLIP:   outval_n = outval_q ^ bus_wdata[N_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outval_q <= '0;
    else     outval_q <= outval_n;
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      A_DIR:     rd_n[MODE_W-1:0] = mode_q;
      A_DRVTYPE: rd_n[N_PINS-1:0] = drvtype_q;
      A_SLEW:    rd_n[MODE_W-1:0] = slew_q;
      A_BIAS:    rd_n[MODE_W-1:0] = bias_q;
      A_FUNC:    rd_n[FUNC_W-1:0] = func_q;
      A_LEVEL:   rd_n[N_PINS-1:0] = level;
      A_OUTVAL:  rd_n[N_PINS-1:0] = outval_q;
      A_FREEZE:  rd_n[0]          = locked;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_n;
    else             bus_rdata <= '0;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_pin_drv #(.AF_SEL_W(AF_SEL_W)) u_drv (
      .clk      (clk),
      .rst      (rst),
      .mode_i   (mode_q[2*p +: 2]),
      .outval_i (outval_q[p]),
      .sel_i    (func_q[AF_SEL_W*p +: AF_SEL_W]),
      .af_src_i (af_src_i[NUM_AF*p +: NUM_AF]),
      .pad_o    (pad_o[p]),
      .pad_oe   (pad_oe[p])
    );
  end

  // R8: frozen configuration does not move
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(mode_q) && $stable(func_q) && $stable(drvtype_q)
                && $stable(slew_q) && $stable(bias_q)));

  // R4: every bit marked for set ends high, even if also marked for clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SETCLR) |=>
      ((outval_q & $past(set_m)) == $past(set_m)));

  // R4: bits marked only for clear end low
  assert_clear_only_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SETCLR) |=>
      ((outval_q & $past(clr_m & ~set_m)) == '0));

  // R5: flip inverts exactly the marked bits
  assert_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_FLIP) |=>
      (outval_q == ($past(outval_q) ^ $past(bus_wdata[N_PINS-1:0]))));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int N  = 8;
  localparam int DW = 32;
  localparam logic [15:0] KEY = 16'hC35A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  pad_i = '0;
  logic [N-1:0]  pad_o, pad_oe;
  logic [N*4-1:0] af_src_i = '0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_port i_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .af_src_i(af_src_i)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [0:12] = '{
    '{4'd1, 32'hFFFF_FFA5, 4'd1, 32'h0000_00A5, 8'd11}, // R11 drive type
    '{4'd2, 32'h1234_BEEF, 4'd2, 32'h0000_BEEF, 8'd11}, // R11 slew
    '{4'd3, 32'h0000_7E81, 4'd3, 32'h0000_7E81, 8'd11}, // R11 bias
    '{4'd4, 32'h0000_E41B, 4'd4, 32'h0000_E41B, 8'd7},  // R7 selector store
    '{4'd6, 32'h0000_005A, 4'd6, 32'h0000_005A, 8'd3},  // R3 full write
    '{4'd7, 32'h0000_0081, 4'd6, 32'h0000_00DB, 8'd4},  // R4 set only
    '{4'd7, 32'h0000_0A00, 4'd6, 32'h0000_00D1, 8'd4},  // R4 clear only
    '{4'd7, 32'h0000_0F0F, 4'd6, 32'h0000_00DF, 8'd4},  // R4 set wins
    '{4'd8, 32'h0000_00FF, 4'd6, 32'h0000_0020, 8'd5},  // R5 flip all
    '{4'd8, 32'h0000_0021, 4'd6, 32'h0000_0001, 8'd5},  // R5 flip some
    '{4'd7, 32'h0000_0000, 4'd6, 32'h0000_0001, 8'd4},  // R4 empty write
    '{4'd6, 32'h0000_00A5, 4'd6, 32'h0000_00A5, 8'd3},  // R3 rewrite
    '{4'd7, 32'h0000_FF00, 4'd6, 32'h0000_0000, 8'd4}   // R4 clear all
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic freeze_seq(input logic [15:0] k);
    logic [31:0] dummy;
    wr(4'd9, {k, 16'h0001});
    wr(4'd9, {k, 16'h0000});
    wr(4'd9, {k, 16'h0001});
    rd(4'd9, dummy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe", {24'h0, pad_oe}, 32'h03);
    check("R1 pad_o", {24'h0, pad_o}, 32'h00);
    rd(4'd0, r); check("R1 dir", r, 32'h0000_000A);
    rd(4'd6, r); check("R1 outval", r, 32'h0);
    rd(4'd9, r); check("R1 freeze", r, 32'h0);

    for (int i = 0; i <= 12; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, r);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), r, VECS[i].ex);
    end

    // R6 mixed modes: pins 7..4 output, 3..2 input, 1..0 alternate
    wr(4'd6, 32'h0000_00A5);
    wr(4'd0, 32'h0000_550A);
    @(negedge clk);
    check("R6 oe", {24'h0, pad_oe}, 32'h0000_00F3);
    check("R6 out", {24'h0, pad_o & 8'hFC}, 32'h0000_00A0);

    // R7 pin0 selects source 3, pin1 selects source 2
    @(negedge clk);
    af_src_i = 32'h0000_00B8;
    @(negedge clk);
    check("R7 sel a", {30'h0, pad_o[1:0]}, 32'h1);
    af_src_i = 32'h0000_0040;
    @(negedge clk);
    check("R7 sel b", {30'h0, pad_o[1:0]}, 32'h2);

    // R2 level read ignores mode (pins 4..7 are outputs)
    pad_i = 8'h3C;
    repeat (2) @(negedge clk);
    rd(4'd5, r); check("R2 level", r, 32'h0000_003C);
    pad_i = 8'hC3;
    repeat (2) @(negedge clk);
    rd(4'd5, r); check("R2 level 2", r, 32'h0000_00C3);

    // R9 wrong order and wrong key
    wr(4'd9, {KEY, 16'h0001});
    wr(4'd9, {KEY, 16'h0001});
    wr(4'd9, {KEY, 16'h0000});
    wr(4'd9, {KEY, 16'h0001});
    rd(4'd9, r);
    rd(4'd9, r); check("R9 order", r, 32'h0);
    freeze_seq(16'h1234);
    rd(4'd9, r); check("R9 key", r, 32'h0);
    wr(4'd4, 32'h0000_1111);
    rd(4'd4, r); check("R9 still writable", r, 32'h0000_1111);
    wr(4'd4, 32'h0000_E41B);

    // R8 correct handshake
    freeze_seq(KEY);
    rd(4'd9, r); check("R8 frozen", r, 32'h1);
    wr(4'd0, 32'h0000_FFFF);
    rd(4'd0, r); check("R8 dir held", r, 32'h0000_550A);
    wr(4'd4, 32'h0);
    rd(4'd4, r); check("R8 func held", r, 32'h0000_E41B);
    wr(4'd1, 32'h0);
    rd(4'd1, r); check("R8 drvtype held", r, 32'h0000_00A5);
    wr(4'd6, 32'h0000_003C);
    rd(4'd6, r); check("R8 outval live", r, 32'h0000_003C);
    @(negedge clk);
    check("R8 pads still driven", {24'h0, pad_oe}, 32'h0000_00F3);

    // R10 unlock attempt, then reset
    wr(4'd9, {KEY, 16'h0000});
    wr(4'd9, 32'h0);
    rd(4'd9, r); check("R10 stays frozen", r, 32'h1);
    do_reset();
    rd(4'd9, r); check("R10 reset clears", r, 32'h0);
    rd(4'd0, r); check("R10 dir reset", r, 32'h0000_000A);
    wr(4'd0, 32'h0000_0005);
    rd(4'd0, r); check("R10 writable", r, 32'h0000_0005);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule